// File: doc/BRIEF.md
# 64-bit Prescaled Timebase with Snapshot and Preset

This block is a free-running 64-bit tick counter for system timekeeping. It is reached through 32-bit register accesses. A programmable divisor slows the count, so the counter advances once every D+1 input clocks. Because a 64-bit value cannot be read in one 32-bit access without tearing, software writes a command that copies the whole count into a pair of snapshot registers in one cycle. It then reads the two halves at its own pace.

To preset the counter, software first writes the two halves of the new value into staging registers. A second command then moves the staged value into the counter in one cycle. Commands are strobes in the two low bits of the control register. They read back as zero. The divisor field in the upper half of the same register keeps whatever was last written to it.

Top module: `timebase64`

## Requirements
- R1: After reset the count, the staging registers, the snapshot registers and the divisor are all zero. The counter then advances by one on every clock.
- R2: With divisor D held in control bits [31:16], the count advances by exactly one every D+1 clocks.
- R3: A control write with bits [1:0] = 01 copies the count of that cycle into the snapshot registers, which read at 0x7C (low word) and 0x80 (high word).
- R4: A control write with bits [1:0] = 11 places the staging value (0x74 low, 0x78 high) into the counter at that edge. A tick due in the same cycle is dropped, and the next increment follows D+1 clocks later.
- R5: Control reads return the divisor in bits [31:16] and zero in bits [15:0]. Any control write updates the divisor. A control write with bits [1:0] = 10 leaves the count and the snapshot unchanged.
- R6: The snapshot registers keep their value until the next snapshot command, however far the count moves.
- R7: The live count reads at 0x6C (low) and 0x70 (high). The staging registers read back what was written to them. Writes to the live and snapshot addresses have no effect.
- R8: The count carries from the low word into the high word and wraps from all ones to zero only at 2^64.
- R9: Reads of any address outside the seven mapped offsets (control at 0x68) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |

## Verification
The bench presets the counter next to both carry boundaries, with low word all ones and with the full 64 bits all ones. A design with a broken carry or an early wrap would then read back a wrong high word. It issues a preset while the divisor is zero, so a tick is due on the load edge. A design that let the tick win would show the preset value plus one. Random divisors, preset values and waits compare the count and the snapshot against a formula. An off-by-one prescaler, or a prescaler that is not restarted by the preset, drifts from that formula. The bench also writes the 10 command pattern and writes to the read-only addresses, then confirms that the count kept its normal pace and the snapshot did not move.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
    localparam int WORD_W = 32;

    // register byte offsets (fixed: software decodes them)
    localparam int OFF_CTRL  = 'h68;
    localparam int OFF_CNT_L = 'h6C;
    localparam int OFF_CNT_H = 'h70;
    localparam int OFF_LD_L  = 'h74;
    localparam int OFF_LD_H  = 'h78;
    localparam int OFF_LAT_L = 'h7C;
    localparam int OFF_LAT_H = 'h80;

    localparam int DIV_LSB = 16;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_SNAP  = 2'd1,
        CMD_PRESET = 2'd2
    } tb_cmd_e;

    // strobe bits [1:0]: 01 snapshot, 11 preset, others nothing
    function automatic tb_cmd_e decode_cmd(input logic [1:0] bits);
        case (bits)
            2'b01:   return CMD_SNAP;
            2'b11:   return CMD_PRESET;
            default: return CMD_NONE;
        endcase
    endfunction
endpackage

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    input  logic             restart_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] phase_q;

    // >= so that lowering the divisor never stalls the count
    assign tick_o = (phase_q >= div_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (restart_i || tick_o) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count_o <= '0;
        end else if (load_i) begin
            count_o <= load_val_i;
        end else if (tick_i) begin
            count_o <= count_o + 1'b1;
        end
    end
endmodule

// File: rtl/tbase_regs.sv
module tbase_regs
    import tbase_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DIV_W = 16,
    parameter int CNT_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count_i,
    output logic [DIV_W-1:0]  div_o,
    output logic              load_o,
    output logic [CNT_W-1:0]  load_val_o,
    output logic [CNT_W-1:0]  snap_o,
    output logic [WORD_W-1:0] rdata
);
    localparam int NWORDS = CNT_W / WORD_W;

    tb_cmd_e cmd;
    logic    ctrl_wr;

    assign ctrl_wr = wr_en && (addr == AW'(OFF_CTRL));
    assign cmd     = ctrl_wr ? decode_cmd(wdata[1:0]) : CMD_NONE;
    assign load_o  = (cmd == CMD_PRESET);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_o <= '0;
        end else if (ctrl_wr) begin
            div_o <= wdata[DIV_LSB +: DIV_W];
        end
    end

    // staging and snapshot words, one generated slice per 32-bit word
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        localparam int LD_OFF = OFF_LD_L + 4 * w;
        always_ff @(posedge clk) begin
            if (rst) begin
                load_val_o[w*WORD_W +: WORD_W] <= '0;
                snap_o[w*WORD_W +: WORD_W]     <= '0;
            end else begin
                if (wr_en && (addr == AW'(LD_OFF))) begin
                    load_val_o[w*WORD_W +: WORD_W] <= wdata;
                end
                if (cmd == CMD_SNAP) begin
                    snap_o[w*WORD_W +: WORD_W] <= count_i[w*WORD_W +: WORD_W];
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            AW'(OFF_CTRL):  rdata[DIV_LSB +: DIV_W] = div_o;
            AW'(OFF_CNT_L): rdata = count_i[0 +: WORD_W];
            AW'(OFF_CNT_H): rdata = count_i[WORD_W +: WORD_W];
            AW'(OFF_LD_L):  rdata = load_val_o[0 +: WORD_W];
            AW'(OFF_LD_H):  rdata = load_val_o[WORD_W +: WORD_W];
            AW'(OFF_LAT_L): rdata = snap_o[0 +: WORD_W];
            AW'(OFF_LAT_H): rdata = snap_o[WORD_W +: WORD_W];
            default:        rdata = '0;
        endcase
    end
endmodule

// File: rtl/timebase64.sv
module timebase64 #(
    parameter int AW    = 8,
    parameter int DIV_W = 16,
    parameter int CNT_W = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata
);
    logic [DIV_W-1:0] div_w;
    logic             tick_w;
    logic             load_w;
    logic [CNT_W-1:0] ldv_w;
    logic [CNT_W-1:0] count_w;
    logic [CNT_W-1:0] snap_w;

    tbase_regs #(.AW(AW), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr[AW-1:0]),
        .wdata(wdata), .count_i(count_w), .div_o(div_w), .load_o(load_w),
        .load_val_o(ldv_w), .snap_o(snap_w), .rdata(rdata)
    );

    tbase_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk(clk), .rst(rst), .div_i(div_w), .restart_i(load_w), .tick_o(tick_w)
    );

    tbase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick_i(tick_w), .load_i(load_w),
        .load_val_i(ldv_w), .count_o(count_w)
    );
endmodule

// File: rtl/timebase64_checker.sv
module timebase64_checker
    import tbase_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [7:0]       addr,
    input logic [31:0]      wdata,
    input logic [31:0]      rdata,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] ldv,
    input logic [CNT_W-1:0] snap
);
    logic ctl;
    assign ctl = wr_en && (addr == 8'(OFF_CTRL));

    // R4: preset command puts the staged value into the count
    p_preset_r4: assert property (@(posedge clk) disable iff (rst)
        (ctl && wdata[1:0] == 2'b11) |=> (count == $past(ldv)));

    // R3: snapshot command captures the count of the command cycle
    p_snap_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl && wdata[1:0] == 2'b01) |=> (snap == $past(count)));

    // R6: snapshot holds without a command
    p_snap_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(ctl && wdata[1:0] == 2'b01) |=> $stable(snap));

    // R2: without a preset the count moves by at most one
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        !(ctl && wdata[1:0] == 2'b11) |=>
            (count == $past(count) || count == $past(count) + 1'b1));

    // R5: control reads carry no strobe bits
    p_ctrl_rd_r5: assert property (@(posedge clk) disable iff (rst)
        (addr == 8'(OFF_CTRL)) |-> (rdata[15:0] == 16'h0));
endmodule

bind timebase64 timebase64_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .count(count_w), .ldv(ldv_w), .snap(snap_w)
);

// File: tb/timebase64_test.sv
module timebase64_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    timebase64 uut (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
                    .wdata(wdata), .rdata(rdata));

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [63:0] expect_cnt(input logic [63:0] base,
                                               input int edges, input int d);
        return base + 64'(edges / (d + 1));
    endfunction

    function automatic logic [31:0] ctrl_word(input int d, input logic [1:0] c);
        return {d[15:0], 14'h0, c};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h0; wdata = 32'h0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic rd64(input logic [7:0] a, output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(a, lo); rd(a + 8'd4, hi);
        v = {hi, lo};
        addr = 8'h0;
    endtask

    task automatic preset(input logic [63:0] v, input int d);
        wr(8'h74, v[31:0]);
        wr(8'h78, v[63:32]);
        wr(8'h68, ctrl_word(d, 2'b11));
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] v, snap0;
        logic [31:0] w;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, then runs at full rate
        rd64(8'h6C, v);  check("R1 count", v, 64'h0);
        rd64(8'h74, v);  check("R1 staging", v, 64'h0);
        rd64(8'h7C, v);  check("R1 snapshot", v, 64'h0);
        rd(8'h68, w);    check("R1 ctrl", 64'(w), 64'h0);
        repeat (4) @(negedge clk);
        rd64(8'h6C, v);  check("R1 runs", v, 64'd4);

        // R9: unmapped addresses
        rd(8'h00, w); check("R9 addr 0x00", 64'(w), 64'h0);
        rd(8'h84, w); check("R9 addr 0x84", 64'(w), 64'h0);
        rd(8'h6A, w); check("R9 addr 0x6A", 64'(w), 64'h0);

        // R4: tick due on the preset edge is dropped (D=0)
        preset(64'h0123_4567_89AB_CDEF, 0);
        rd64(8'h6C, v); check("R4 preset wins", v, 64'h0123_4567_89AB_CDEF);
        rd64(8'h74, v); check("R7 staging readback", v, 64'h0123_4567_89AB_CDEF);

        // R8: carry and wrap
        preset(64'h0000_0000_FFFF_FFFF, 0);
        @(negedge clk);
        rd64(8'h6C, v); check("R8 carry", v, 64'h0000_0001_0000_0000);
        preset(64'hFFFF_FFFF_FFFF_FFFF, 0);
        @(negedge clk);
        rd64(8'h6C, v); check("R8 wrap", v, 64'h0);

        // R5 / R6 / R7: pattern 10 and read-only writes have no effect
        preset(64'h100, 0);
        wr(8'h68, ctrl_word(0, 2'b01));
        rd64(8'h7C, snap0); check("R3 snap D0", snap0, 64'h100);
        wr(8'h68, ctrl_word(0, 2'b10));
        rd64(8'h6C, v); check("R5 pattern 10 count", v, 64'h102);
        rd64(8'h7C, v); check("R5 pattern 10 snap", v, 64'h100);
        wr(8'h6C, 32'hDEAD_BEEF);
        wr(8'h70, 32'hDEAD_BEEF);
        wr(8'h7C, 32'hDEAD_BEEF);
        rd64(8'h6C, v); check("R7 live write ignored", v, 64'h105);
        rd64(8'h7C, v); check("R7 snap write ignored", v, 64'h100);
        rd(8'h68, w);   check("R5 ctrl readback D0", 64'(w), 64'h0);

        // random: divisor, preset, snapshot, hold
        for (int it = 0; it < 24; it++) begin
            int d, k, m;
            logic [63:0] base, e;
            d = int'($urandom_range(0, 6));
            k = int'($urandom_range(0, 20));
            m = int'($urandom_range(1, 12));
            base = {$urandom, $urandom};
            if (it == 3) base = 64'hFFFF_FFFF_FFFF_FFFE;
            preset(base, d);
            rd(8'h68, w); check("R5 ctrl readback", 64'(w), 64'(ctrl_word(d, 2'b00)));
            repeat (k) @(negedge clk);
            e = expect_cnt(base, k, d);
            rd64(8'h6C, v); check("R2 rate", v, e);
            wr(8'h68, ctrl_word(d, 2'b01));
            repeat (m) @(negedge clk);
            rd64(8'h7C, v); check("R3 snapshot value", v, e);
            check("R6 snapshot held", v, e);
            rd64(8'h6C, v); check("R2 rate after snap", v, expect_cnt(base, k + 1 + m, d));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule